// File: doc/BRIEF.md
# Duplicated Datapath Compare-and-Hold Controller

This block runs two identical copies of a registered datapath side by side and compares their results on every cycle. A disagreement does not start a vote. Instead the block raises `hold` in the same cycle, which freezes the iterative controller around it at its current step. It then looks once more on the following cycle.

A radiation glitch on combinational logic lasts about a nanosecond, which is well under one clock period. A single-cycle disagreement is therefore treated as transient and counted, and the run continues with no repair. If the copies still disagree on the second look, the block asks an external configuration-scrub engine for a repair. It stays in hold until that engine pulses `repair_done`, then waits one settling cycle before it releases the controller.

The copies are placeholders that compute `(a*b) XOR (a+b)`, truncated to the data width. Each copy accepts an XOR upset mask on its result, so that faults can be modelled on demand. While `hold` is high, no result is marked valid.

Top module: `dmch_top`

## Requirements
- R1: While reset is active and in the first cycle after reset, the outputs `hold`, `repair_req` and `res_valid` are 0, and both event counters are 0.
- R2: When the copies agree, `res_valid` equals `in_valid` one cycle later. In that same cycle `res_data` equals the low DW bits of `(op_a*op_b) XOR (op_a+op_b)`, taken from the operands presented one cycle earlier.
- R3: In the running state, `hold` goes high in the same cycle that the two copy results differ.
- R4: `res_valid` is 0 whenever `hold` is 1.
- R5: A disagreement that lasts exactly one cycle holds for two cycles: the mismatch cycle and the check cycle. It then releases `hold` and never raises `repair_req`. It also increments `transient_cnt` by one, and that new value is visible once `hold` has dropped.
- R6: A disagreement seen on two consecutive cycles raises `repair_req` in the next cycle and increments `repair_cnt` by one in that same cycle.
- R7: `repair_req` stays high until a cycle in which `repair_done` is 1. After that cycle there is one settling cycle with `repair_req` low and `hold` high, and then `hold` drops, provided the copies agree.
- R8: `repair_done` is ignored when no repair is pending: `hold`, `repair_req` and both counters stay unchanged.
- R9: Both event counters saturate at all ones (255 for the default 8-bit width) and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands are valid this cycle |
| op_a | input | DW | First operand, fed to both copies |
| op_b | input | DW | Second operand, fed to both copies |
| upset_a | input | DW | XOR fault mask applied to the result of copy 0 |
| upset_b | input | DW | XOR fault mask applied to the result of copy 1 |
| repair_done | input | 1 | Pulse from the scrub engine: repair finished |
| res_data | output | DW | Result taken from copy 0 |
| res_valid | output | 1 | Result is valid and may be committed |
| hold | output | 1 | Freeze the surrounding iteration |
| repair_req | output | 1 | Request a repair from the scrub engine |
| transient_cnt | output | CW | Saturating count of transient disagreements |
| repair_cnt | output | CW | Saturating count of repair requests |

## Verification
The completion pulse and the start of a repair can fall in the same cycle. The bench provokes this by holding a mismatch for two cycles and then driving `repair_done` in the very first cycle that `repair_req` is high. The expected result is `repair_req` high for exactly that one cycle, followed by a normal settling cycle with `hold` high and `repair_cnt` advanced by one. A second overlap also gets a check: a completion pulse that arrives while the block is running must leave every output unchanged.

// File: rtl/dmch_pkg.sv
package dmch_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_CHECK  = 2'd1,
    ST_REPAIR = 2'd2,
    ST_SETTLE = 2'd3
  } dmch_state_e;

  // Placeholder datapath: product XOR sum, truncated to DW bits
  function automatic logic [63:0] dp_calc(input logic [63:0] a, input logic [63:0] b);
    return (a * b) ^ (a + b);
  endfunction

  // Saturating increment of a W-bit value held in a 32-bit container
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] vmax);
    return (v >= vmax) ? vmax : v + 32'd1;
  endfunction

endpackage

// File: rtl/dmch_copy.sv
module dmch_copy #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [DW-1:0] upset,
  output logic [DW-1:0] result
);
  import dmch_pkg::*;

  logic [DW-1:0] res_q;
  logic [63:0]   calc;

  always_comb calc = dp_calc(64'(op_a), 64'(op_b));

  always_ff @(posedge clk) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= calc[DW-1:0];
  end

  assign result = res_q ^ upset;
endmodule

// File: rtl/dmch_evcnt.sv
module dmch_evcnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bump,
  output logic [CW-1:0] count
);
  import dmch_pkg::*;

  localparam logic [31:0] CMAX = 32'((64'd1 << CW) - 64'd1);

  logic [31:0] nxt;

  always_comb nxt = sat_inc(32'(count), CMAX);

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (bump) count <= nxt[CW-1:0];
  end
endmodule

// File: rtl/dmch_ctrl.sv
module dmch_ctrl (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mismatch,
  input  logic                  repair_done,
  output dmch_pkg::dmch_state_e state,
  output logic                  hold,
  output logic                  repair_req,
  output logic                  ev_transient,
  output logic                  ev_repair
);
  import dmch_pkg::*;

  dmch_state_e nxt;

  always_comb begin
    nxt          = state;
    ev_transient = 1'b0;
    ev_repair    = 1'b0;
    unique case (state)
      ST_RUN:    if (mismatch) nxt = ST_CHECK;
      ST_CHECK: begin
        if (mismatch) begin
          nxt       = ST_REPAIR;
          ev_repair = 1'b1;
        end else begin
          nxt          = ST_RUN;
          ev_transient = 1'b1;
        end
      end
      ST_REPAIR: if (repair_done) nxt = ST_SETTLE;
      ST_SETTLE: nxt = ST_RUN;
      default:   nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= nxt;
  end

  assign hold       = (state != ST_RUN) | mismatch;
  assign repair_req = (state == ST_REPAIR);
endmodule

// File: rtl/dmch_top.sv
module dmch_top #(
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [DW-1:0] upset_a,
  input  logic [DW-1:0] upset_b,
  input  logic          repair_done,
  output logic [DW-1:0] res_data,
  output logic          res_valid,
  output logic          hold,
  output logic          repair_req,
  output logic [CW-1:0] transient_cnt,
  output logic [CW-1:0] repair_cnt
);
  import dmch_pkg::*;

  localparam int NCOPY = 2;

  logic [DW-1:0] upset_v  [NCOPY];
  logic [DW-1:0] copy_res [NCOPY];
  logic          valid_q;

  // Named internal events for the checker
  logic          ev_mismatch;
  logic          ev_transient;
  logic          ev_repair;
  logic          in_run;
  dmch_state_e   state;

  assign upset_v[0] = upset_a;
  assign upset_v[1] = upset_b;

  for (genvar g = 0; g < NCOPY; g++) begin : g_copy
    dmch_copy #(.DW(DW)) u_copy (
      .clk    (clk),
      .rst_n  (rst_n),
      .op_a   (op_a),
      .op_b   (op_b),
      .upset  (upset_v[g]),
      .result (copy_res[g])
    );
  end

  assign ev_mismatch = (copy_res[0] != copy_res[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= in_valid;
  end

  dmch_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .mismatch     (ev_mismatch),
    .repair_done  (repair_done),
    .state        (state),
    .hold         (hold),
    .repair_req   (repair_req),
    .ev_transient (ev_transient),
    .ev_repair    (ev_repair)
  );

  assign in_run = (state == ST_RUN);

  dmch_evcnt #(.CW(CW)) u_cnt_tr (
    .clk (clk), .rst_n (rst_n), .bump (ev_transient), .count (transient_cnt)
  );

  dmch_evcnt #(.CW(CW)) u_cnt_rp (
    .clk (clk), .rst_n (rst_n), .bump (ev_repair), .count (repair_cnt)
  );

  assign res_data  = copy_res[0];
  assign res_valid = valid_q & ~hold;
endmodule

// File: rtl/dmch_chk.sv
module dmch_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mismatch,
  input logic          in_run,
  input logic          hold,
  input logic          res_valid,
  input logic          repair_req,
  input logic          repair_done,
  input logic          ev_transient,
  input logic          ev_repair,
  input logic [CW-1:0] transient_cnt,
  input logic [CW-1:0] repair_cnt
);

  // R3
  hold_on_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && mismatch) |-> hold);

  // R4
  no_commit_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !res_valid);

  // R5
  transient_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_transient |=> (!repair_req && !hold) || mismatch);

  // R6
  req_after_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_repair |=> repair_req);

  // R7
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (repair_req && !repair_done) |=> repair_req);

  // R7
  settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(repair_req) |-> hold);

  // R8
  stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (repair_done && in_run && !mismatch) |=> $stable(repair_cnt) && !repair_req);

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (transient_cnt >= $past(transient_cnt)) && (repair_cnt >= $past(repair_cnt)));

endmodule

bind dmch_top dmch_chk #(.CW(CW)) u_dmch_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mismatch      (ev_mismatch),
  .in_run        (in_run),
  .hold          (hold),
  .res_valid     (res_valid),
  .repair_req    (repair_req),
  .repair_done   (repair_done),
  .ev_transient  (ev_transient),
  .ev_repair     (ev_repair),
  .transient_cnt (transient_cnt),
  .repair_cnt    (repair_cnt)
);

// File: tb/test_dmch_top.sv
module test_dmch_top;
  localparam int DW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] op_a = '0, op_b = '0, upset_a = '0, upset_b = '0;
  logic          repair_done = 1'b0;
  logic [DW-1:0] res_data;
  logic          res_valid, hold, repair_req;
  logic [CW-1:0] transient_cnt, repair_cnt;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dmch_top #(.DW(DW), .CW(CW)) i_dmch_top (.*);

  // Independent model: 32-bit arithmetic then keep 16 bits
  function automatic logic [15:0] model(input logic [15:0] a, input logic [15:0] b);
    int unsigned x, y;
    x = int'(a) * int'(b);
    y = int'(a) + int'(b);
    return 16'((x ^ y) & 32'hFFFF);
  endfunction

  localparam logic [31:0] VEC [8] = '{
    32'h0000_0000, 32'h0001_0001, 32'hFFFF_FFFF, 32'h1234_5678,
    32'h8000_0002, 32'h00FF_FF00, 32'hAAAA_5555, 32'h0003_7FFF
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int tc0, rc0;
    repeat (3) tick();
    // R1 during reset
    chk(!hold && !repair_req && !res_valid, "R1", {hold, repair_req, res_valid}, 0);
    chk(transient_cnt == 0 && repair_cnt == 0, "R1", transient_cnt + repair_cnt, 0);
    rst_n = 1'b1;
    tick();
    // R1 first cycle after reset
    chk(!hold && !repair_req && !res_valid, "R1", {hold, repair_req, res_valid}, 0);

    // R2 vector walk
    for (int i = 0; i < 8; i++) begin
      op_a = VEC[i][31:16];
      op_b = VEC[i][15:0];
      in_valid = 1'b1;
      tick();
      chk(res_valid == 1'b1, "R2", res_valid, 1);
      chk(res_data == model(VEC[i][31:16], VEC[i][15:0]), "R2", res_data,
          model(VEC[i][31:16], VEC[i][15:0]));
    end
    in_valid = 1'b0;
    tick();
    chk(res_valid == 1'b0, "R2", res_valid, 0);
    in_valid = 1'b1;
    tick();

    // R3 R4 R5 single-cycle transient
    upset_a = 16'h0001;
    #1;
    chk(hold == 1'b1, "R3", hold, 1);
    chk(res_valid == 1'b0, "R4", res_valid, 0);
    tick();
    upset_a = '0;
    #1;
    chk(hold == 1'b1 && repair_req == 1'b0, "R5", {hold, repair_req}, 2);
    tick();
    chk(hold == 1'b0 && repair_req == 1'b0, "R5", {hold, repair_req}, 0);
    chk(transient_cnt == 1, "R5", transient_cnt, 1);
    chk(res_valid == 1'b1, "R4", res_valid, 1);

    // R6 R7 persistent mismatch
    upset_b = 16'h0004;
    tick();
    chk(hold == 1'b1 && repair_req == 1'b0, "R6", {hold, repair_req}, 2);
    tick();
    upset_b = '0;
    #1;
    chk(repair_req == 1'b1, "R6", repair_req, 1);
    chk(repair_cnt == 1, "R6", repair_cnt, 1);
    chk(transient_cnt == 1, "R6", transient_cnt, 1);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(repair_req == 1'b1 && hold == 1'b1, "R7", {repair_req, hold}, 3);
    end
    repair_done = 1'b1;
    tick();
    repair_done = 1'b0;
    #1;
    chk(repair_req == 1'b0 && hold == 1'b1, "R7", {repair_req, hold}, 1);
    chk(res_valid == 1'b0, "R4", res_valid, 0);
    tick();
    chk(hold == 1'b0 && res_valid == 1'b1, "R7", {hold, res_valid}, 1);

    // R8 stray completion pulse while running
    repair_done = 1'b1;
    #1;
    chk(hold == 1'b0, "R8", hold, 0);
    tick();
    repair_done = 1'b0;
    #1;
    chk(hold == 1'b0 && repair_req == 1'b0, "R8", {hold, repair_req}, 0);
    chk(repair_cnt == 1 && transient_cnt == 1, "R8", repair_cnt + transient_cnt, 2);

    // Overlap: completion in the first cycle of the request
    upset_a = 16'h8000;
    tick();
    tick();
    upset_a = '0;
    #1;
    chk(repair_req == 1'b1 && repair_cnt == 2, "R6", repair_cnt, 2);
    repair_done = 1'b1;
    tick();
    repair_done = 1'b0;
    #1;
    chk(repair_req == 1'b0 && hold == 1'b1, "R7", {repair_req, hold}, 1);
    tick();
    chk(hold == 1'b0, "R7", hold, 0);

    // R9 saturation of the transient counter
    tc0 = transient_cnt;
    rc0 = repair_cnt;
    for (int k = 0; k < 300; k++) begin
      upset_a = 16'h0010;
      tick();
      upset_a = '0;
      tick();
    end
    chk(transient_cnt == 255, "R9", transient_cnt, 255);
    chk(repair_cnt == rc0[CW-1:0], "R9", repair_cnt, rc0);
    chk(tc0 == 1, "R9", tc0, 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule